// File: doc/BRIEF.md
# Receive Stream Checksum Appender

This block sits on a byte-wide receive stream between a MAC and a DMA engine. Each byte comes with a valid strobe, and a last flag marks the end of a frame. While a frame passes through, the block keeps a 16-bit ones-complement sum over the bytes that follow the 14-byte Ethernet header. The four trailing frame check bytes are left out of the sum. Every frame byte is forwarded unchanged, one cycle after it is accepted.

When the frame's final byte has gone out, the block emits two more bytes: the checksum, low byte first. The last flag moves onto the second of these bytes, and the reported frame length grows by two. While the two extra bytes go out, the block holds off its input. An enable bit and a mode bit select whether checksum bytes are appended and whether the sum is sent as is or inverted. Both bits are captured when the first byte of a frame is accepted.

The control follows a four-state machine:
- `ST_IDLE` waits for the first byte of a frame and captures the configuration.
- `ST_BODY` forwards the remaining bytes.
- `ST_CS_LO` emits the low checksum byte.
- `ST_CS_HI` emits the high checksum byte together with last and the length.

The transitions are:
- IDLE→BODY: a first byte without last is accepted.
- IDLE→CS_LO or BODY→CS_LO: a byte with last is accepted in an enabled frame.
- IDLE→IDLE or BODY→IDLE: a byte with last is accepted in a disabled frame.
- CS_LO→CS_HI and CS_HI→IDLE: these are unconditional.

Top module: `rx_csum_appender`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid and len_valid are 0. After reset, in_ready is 1.
- R2: In an enabled frame, every accepted input byte appears on out_data one cycle after acceptance, unchanged and in order, with out_last 0.
- R3: The checksum is computed over frame byte offsets 14 up to L-5, where L is the frame length. Bytes are paired into 16-bit words with the earlier byte as the low half. An odd final byte is paired with a zero high half. Every carry out of bit 15 is added back into the sum.
- R4: After the final byte of an enabled frame, two bytes follow on consecutive cycles: checksum bits 7:0 first, then bits 15:8. out_last is 1 only on the second of them.
- R5: len_valid pulses in the same cycle as out_last, and out_len carries the frame length. That length is L+2 when the frame was enabled and L when it was not.
- R6: In a disabled frame, the bytes pass through unchanged with out_last on the original final byte, and nothing is appended.
- R7: With mode 1 the appended value is the bitwise complement of the sum. With mode 0 it is the sum itself.
- R8: cfg_en and cfg_mode are captured only when the first byte of a frame is accepted. A change made later in the frame affects only the next frame.
- R9: After the final byte of an enabled frame is accepted, in_ready is 0 for exactly two cycles and then returns to 1. For a disabled frame, in_ready stays 1.
- R10: A frame of 18 bytes or fewer sums no bytes. It appends 0x0000 with mode 0 and 0xFFFF with mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Enables checksum appending (captured at frame start) |
| cfg_mode | input | 1 | 0: raw sum, 1: complemented sum (captured at frame start) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the frame's final byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte ends the frame |
| len_valid | output | 1 | out_len is valid this cycle |
| out_len | output | 16 | Reported frame length |

## Verification
Some properties are checked on every cycle:
- After the final byte of an enabled frame, the input is held off for exactly two cycles.
- The forwarded byte is followed by two more valid beats, with last only on the third.
- A length report never appears without last.
- A disabled frame's bytes are copied to the output one cycle later.
- The captured configuration does not move inside a frame.

The bench's scenarios are needed for the rest. They compare the appended checksum against an independent word-pairing model, for both byte parities, both modes, and frames too short to reach the summed region. They also check the exact reported length, and show that flipping the enable and mode bits mid-frame leaves the current frame alone.

// File: rtl/rxca_pkg.sv
package rxca_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BODY  = 2'd1,
        ST_CS_LO = 2'd2,
        ST_CS_HI = 2'd3
    } rxca_state_e;

    // 16-bit ones-complement addition with end-around carry
    function automatic logic [15:0] ones_add16(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] t;
        t = {1'b0, a} + {1'b0, b};
        return t[15:0] + {15'd0, t[16]};
    endfunction

endpackage

// File: rtl/rxca_tail_delay.sv
// Holds the most recent DEPTH accepted bytes; dout is the byte DEPTH positions back.
module rxca_tail_delay #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage[g] <= '0;
            end else if (shift) begin
                if (g == 0) begin
                    stage[g] <= din;
                end else begin
                    stage[g] <= stage[g-1];
                end
            end
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/rxca_csum_acc.sv
// Running 16-bit ones-complement sum, one byte per add, placed in the low or high half.
module rxca_csum_acc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        add_en,
    input  logic        add_hi,
    input  logic [7:0]  byte_in,
    output logic [15:0] sum
);
    import rxca_pkg::*;

    logic [15:0] word;

    always_comb begin
        word = add_hi ? {byte_in, 8'h00} : {8'h00, byte_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum <= '0;
        end else if (add_en) begin
            sum <= ones_add16(sum, word);
        end
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sum == 16'h0000)); // R10

endmodule

// File: rtl/rx_csum_appender.sv
module rx_csum_appender #(
    parameter int LEN_W     = 16,
    parameter int HDR_BYTES = 14,
    parameter int FCS_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_mode,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             len_valid,
    output logic [LEN_W-1:0] out_len
);
    import rxca_pkg::*;

    localparam int SUM_START = HDR_BYTES + FCS_BYTES;

    rxca_state_e state, state_nx;
    logic             en_q, mode_q;
    logic [LEN_W-1:0] cnt;

    logic             accept, first, eff_en;
    logic [LEN_W-1:0] idx, rel;
    logic             add_en, add_hi;
    logic [7:0]       delayed;
    logic [15:0]      sum, csum_fin;

    assign in_ready = (state == ST_IDLE) || (state == ST_BODY);
    assign accept   = in_valid && in_ready;
    assign first    = accept && (state == ST_IDLE);
    assign eff_en   = first ? cfg_en : en_q;
    assign idx      = first ? '0 : cnt;
    assign rel      = idx - LEN_W'(SUM_START);
    assign add_en   = accept && (idx >= LEN_W'(SUM_START));
    assign add_hi   = rel[0];
    assign csum_fin = mode_q ? ~sum : sum;

    rxca_tail_delay #(.DEPTH(FCS_BYTES), .W(8)) u_tail (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (accept),
        .din   (in_data),
        .dout  (delayed)
    );

    rxca_csum_acc u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (first),
        .add_en  (add_en),
        .add_hi  (add_hi),
        .byte_in (delayed),
        .sum     (sum)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_BODY: begin
                if (accept) begin
                    if (in_last) begin
                        state_nx = eff_en ? ST_CS_LO : ST_IDLE;
                    end else begin
                        state_nx = ST_BODY;
                    end
                end
            end
            ST_CS_LO: state_nx = ST_CS_HI;
            ST_CS_HI: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and frame context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            en_q   <= 1'b0;
            mode_q <= 1'b0;
            cnt    <= '0;
        end else begin
            state <= state_nx;
            if (first) begin
                en_q   <= cfg_en;
                mode_q <= cfg_mode;
            end
            if (accept) begin
                cnt <= idx + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
            len_valid <= 1'b0;
            out_len   <= '0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            len_valid <= 1'b0;
            unique case (state)
                ST_IDLE, ST_BODY: begin
                    if (accept) begin
                        out_valid <= 1'b1;
                        out_data  <= in_data;
                        if (in_last && !eff_en) begin
                            out_last  <= 1'b1;
                            len_valid <= 1'b1;
                            out_len   <= idx + 1'b1;
                        end
                    end
                end
                ST_CS_LO: begin
                    out_valid <= 1'b1;
                    out_data  <= csum_fin[7:0];
                end
                ST_CS_HI: begin
                    out_valid <= 1'b1;
                    out_data  <= csum_fin[15:8];
                    out_last  <= 1'b1;
                    len_valid <= 1'b1;
                    out_len   <= cnt + LEN_W'(2);
                end
                default: ;
            endcase
        end
    end

    AST_HOLD_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last && eff_en) |=> !in_ready ##1 !in_ready ##1 in_ready); // R9
    AST_APPEND_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last && eff_en) |=> (out_valid && !out_last) ##1 (out_valid && !out_last)
                                          ##1 (out_valid && out_last)); // R4
    AST_LEN_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        len_valid |-> (out_last && out_valid)); // R5
    AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !eff_en) |=> (out_valid && out_data == $past(in_data)
                                 && out_last == $past(in_last))); // R6
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(en_q) && $stable(mode_q))); // R8

endmodule

// File: tb/rx_csum_appender_tb_top.sv
module rx_csum_appender_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_mode = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, out_valid, out_last, len_valid;
    logic [7:0]  out_data;
    logic [15:0] out_len;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done_flag = 0;

    logic [8:0] exp_q[$];
    string      tag_q[$];
    int         len_q[$];
    logic [7:0] frame_buf [0:255];

    always #10 clk = ~clk;

    rx_csum_appender dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .len_valid(len_valid), .out_len(out_len)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // independent model: pair words, accumulate wide, fold at the end (R3)
    function automatic logic [15:0] ref_sum(input int len);
        int unsigned acc = 0;
        for (int j = 14; j < len - 4; j += 2) begin
            logic [7:0] lo, hi;
            lo = frame_buf[j];
            hi = (j + 1 < len - 4) ? frame_buf[j+1] : 8'h00;
            acc += {16'h0, hi, lo};
        end
        while (acc >> 16 != 0) acc = (acc & 32'hFFFF) + (acc >> 16);
        return acc[15:0];
    endfunction

    task automatic send_frame(input int len, input int seed, input bit en, input bit mode,
                              input int flip_at);
        logic [15:0] cs;
        for (int i = 0; i < len; i++) begin
            frame_buf[i] = 8'((seed * 37 + i * 13 + i * i) & 255);
            exp_q.push_back({(!en && i == len - 1), frame_buf[i]});
            tag_q.push_back(en ? "R2" : "R6");
        end
        if (en) begin
            cs = ref_sum(len);
            if (mode) cs = ~cs;
            exp_q.push_back({1'b0, cs[7:0]});
            tag_q.push_back(len < 19 ? "R10" : (mode ? "R7/R4" : "R3/R4"));
            exp_q.push_back({1'b1, cs[15:8]});
            tag_q.push_back(len < 19 ? "R10" : (mode ? "R7/R4" : "R3/R4"));
        end
        len_q.push_back(en ? len + 2 : len);
        cfg_en   = en;
        cfg_mode = mode;
        for (int i = 0; i < len; i++) begin
            bit ok;
            if (i == flip_at) begin
                cfg_en   = !en;   // R8: mid-frame change must not apply
                cfg_mode = !mode;
            end
            in_valid = 1'b1;
            in_data  = frame_buf[i];
            in_last  = (i == len - 1);
            forever begin
                ok = in_ready;
                @(negedge clk);
                if (ok) break;
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (en) begin
            check(in_ready == 1'b0, "R9 hold cycle 1", in_ready, 0);
            @(negedge clk);
            check(in_ready == 1'b0, "R9 hold cycle 2", in_ready, 0);
            @(negedge clk);
            check(in_ready == 1'b1, "R9 release", in_ready, 1);
        end else begin
            check(in_ready == 1'b1, "R9 disabled no hold", in_ready, 1);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected output", {out_last, out_data}, 0);
            end else begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_last, out_data} == e, t, {out_last, out_data}, e);
            end
        end
        if (rst_n && len_valid) begin
            if (len_q.size() == 0) begin
                check(1'b0, "R5 unexpected length", out_len, 0);
            end else begin
                int el;
                el = len_q.pop_front();
                check(out_len == 16'(el), "R5 length", out_len, el);
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                check(1'b0, "watchdog", cycles, 0);
                summary();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && len_valid == 1'b0, "R1 in reset", {out_valid, len_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && len_valid == 1'b0, "R1 after reset", {out_valid, len_valid}, 0);
        check(in_ready == 1'b1, "R1 ready", in_ready, 1);

        send_frame(60, 1, 1, 0, -1);   // R3 even payload
        send_frame(61, 2, 1, 0, -1);   // R3 odd payload
        send_frame(64, 3, 1, 1, -1);   // R7
        send_frame(40, 4, 0, 0, -1);   // R6
        send_frame(18, 5, 1, 0, -1);   // R10
        send_frame(10, 6, 1, 1, -1);   // R10 complemented
        send_frame(1, 7, 1, 0, -1);    // R4 single byte
        send_frame(50, 8, 1, 0, 3);    // R8 disable mid-frame
        send_frame(45, 9, 0, 1, 5);    // R8 enable mid-frame
        send_frame(19, 10, 1, 0, -1);  // R3 one summed byte
        send_frame(200, 11, 1, 1, -1); // R3 long frame

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);
        check(len_q.size() == 0, "R5 lengths drained", len_q.size(), 0);
        summary();
    end

endmodule